// File: doc/BRIEF.md
# SD Host Command Issue and Status Controller

This block handles the command side of an SD/MMC host controller. Software-side logic writes a command as a single-cycle strobe. The strobe carries the command index, the response type, and flags for data-present, multi-block and abort, along with the 32-bit argument and the block size and count. The controller accepts the write when it has no request outstanding.

Once accepted, it holds the command until the bus-side inhibit conditions allow a launch. It then presents the finished command word, the argument and the packed block attribute word for one cycle. After that it follows the command stage and the data stage separately until the request finishes.

Completion and error events from the bus engine arrive as single-cycle pulses on a 16-bit source vector. The controller records them in a write-one-to-clear status register, filtered by a status-enable mask. It raises one interrupt line from the status bits that the signal-enable mask lets through.

Any error starts a recovery sequence. The command line is reset first and the data line second. Each reset request stays high until the line reports that it has finished. The request then retires with an error flag.

Top module: `sdc_cmd_ctrl`

## Requirements
- R1: An accepted command is not launched (issue_valid) while cmd_inhibit is high; it launches in the cycle after the first clock edge at which cmd_inhibit is sampled low.
- R2: A command with response type 3 (48-bit with busy) also waits for dat_inhibit to be low, unless its abort flag is set, in which case dat_inhibit is disregarded.
- R3: issue_word packs index in bits 5:0, response type in 7:6 (0 none, 1 136-bit, 2 48-bit, 3 48-bit busy), data-present in 8, multi-block in 9, abort in 10, and auto-stop enable in 11; bit 11 is set exactly when data-present and multi-block are both set.
- R4: issue_attr carries the block size in bits 15:0 and the block count in bits 31:16; issue_arg carries the argument unchanged.
- R5: Event sources by bit: 0 command complete, 1 transfer complete, 2 read ready, 3 write ready, 4 DMA, 5 block gap; 6 to 15 are errors (command timeout, CRC, end-bit, index; data timeout, CRC, end-bit; auto-stop; tuning; DMA). A status bit is set by its event only when its status-enable bit is 1, and is cleared by a clr_we write with a 1 in that bit; an event in the same cycle wins over the clear.
- R6: On acceptance, status bits whose status-enable bit was set are cleared, and both masks are then loaded with all ones.
- R7: A request with data present or a busy response retires only after both command complete and transfer complete have arrived, in either order.
- R8: A request with no data and no busy response retires on command complete alone.
- R9: An error event during an active request raises rst_cmd_req until rst_cmd_done, then rst_dat_req until rst_dat_done, then retires the request with req_err high; the two reset requests are never high together.
- R10: irq is the OR of status bits ANDed with signal-enable; retiring a request clears signal-enable to zero, so irq is low whenever busy is low.
- R11: A command write while busy is high is ignored and produces a one-cycle busy_reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_idx | input | 6 | Command index |
| cmd_rsp | input | 2 | Response type |
| cmd_data | input | 1 | Data stage present |
| cmd_multi | input | 1 | Multi-block transfer |
| cmd_abort | input | 1 | Abort command flag |
| cmd_arg | input | ARG_W | Command argument |
| blk_size | input | BSZ_W | Block size |
| blk_cnt | input | BCNT_W | Block count |
| cmd_inhibit | input | 1 | Command line busy |
| dat_inhibit | input | 1 | Data line busy |
| ev_in | input | 16 | Event pulses by source |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 16 | Ones clear status bits |
| rst_cmd_done | input | 1 | Command line reset finished |
| rst_dat_done | input | 1 | Data line reset finished |
| issue_valid | output | 1 | Command launch pulse |
| issue_word | output | 12 | Launched command word |
| issue_arg | output | ARG_W | Launched argument |
| issue_attr | output | BSZ_W+BCNT_W | Packed block attributes |
| rst_cmd_req | output | 1 | Command line reset request |
| rst_dat_req | output | 1 | Data line reset request |
| int_status | output | 16 | Interrupt status |
| int_sts_en | output | 16 | Status-enable mask |
| int_sig_en | output | 16 | Signal-enable mask |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | Request outstanding |
| busy_reject | output | 1 | Rejected write pulse |
| req_done | output | 1 | Request retired pulse |
| req_err | output | 1 | Retired with error |

## Verification
The bench builds the controller with its default widths: a 32-bit argument and 16-bit block size and count. It uses distinct size and count values, so a swapped half of the attribute word shows up. The event vector is fixed at sixteen sources, so every normal and error bit can be driven. This also makes both completion orders, the busy-with-abort bypass and the two-step line reset reachable in short runs.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int NSRC   = 16;
  localparam int SRC_CC = 0;
  localparam int SRC_TC = 1;
  localparam logic [NSRC-1:0] NORMAL_MASK = 16'h003F;
  localparam logic [NSRC-1:0] ERROR_MASK  = 16'hFFC0;
  localparam logic [NSRC-1:0] ALL_SRC     = NORMAL_MASK | ERROR_MASK;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0, RSP_136 = 2'd1, RSP_48 = 2'd2, RSP_48_BUSY = 2'd3
  } rsp_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ACTIVE, ST_RSTC, ST_RSTD
  } stage_t;

  typedef struct packed {
    logic       auto_stop;
    logic       abort;
    logic       multi;
    logic       data;
    rsp_t       rsp;
    logic [5:0] idx;
  } cmd_word_t;
endpackage

// File: rtl/sdc_issue_gate.sv
module sdc_issue_gate
  import sdc_pkg::*;
(
  input  logic [5:0] wr_idx,
  input  logic [1:0] wr_rsp,
  input  logic       wr_data,
  input  logic       wr_multi,
  input  logic       wr_abort,
  input  cmd_word_t  held,
  input  logic       cmd_inh,
  input  logic       dat_inh,
  output cmd_word_t  built,
  output logic       gate_ok,
  output logic       need_data
);
  logic wait_dat;

  always_comb begin
    built.idx       = wr_idx;
    built.rsp       = rsp_t'(wr_rsp);
    built.data      = wr_data;
    built.multi     = wr_multi;
    built.abort     = wr_abort;
    built.auto_stop = wr_data && wr_multi;
  end

  assign wait_dat  = (held.rsp == RSP_48_BUSY) && !held.abort;
  assign gate_ok   = !cmd_inh && !(wait_dat && dat_inh);
  assign need_data = held.data || (held.rsp == RSP_48_BUSY);
endmodule

// File: rtl/sdc_irq_regs.sv
module sdc_irq_regs
  import sdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_mask,
  input  logic            accept,
  input  logic            sig_clr,
  output logic [NSRC-1:0] sts,
  output logic [NSRC-1:0] sts_en,
  output logic [NSRC-1:0] sig_en,
  output logic            irq
);
  logic [NSRC-1:0] sts_n;

  always_comb begin
    sts_n = sts;
    if (accept) sts_n = sts_n & ~sts_en;
    if (clr_we) sts_n = sts_n & ~clr_mask;
    sts_n = sts_n | (ev & sts_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts    <= '0;
      sts_en <= '0;
      sig_en <= '0;
    end else begin
      sts <= sts_n;
      if (accept) begin
        sts_en <= ALL_SRC;
        sig_en <= ALL_SRC;
      end else if (sig_clr) begin
        sig_en <= '0;
      end
    end
  end

  assign irq = |(sts & sig_en);
endmodule

// File: rtl/sdc_stage_fsm.sv
module sdc_stage_fsm
  import sdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic            gate_ok,
  input  logic            need_data,
  input  logic [NSRC-1:0] ev,
  input  logic            rst_cmd_done,
  input  logic            rst_dat_done,
  output logic            accept,
  output logic            issue_fire,
  output logic            sig_clr,
  output logic            busy,
  output logic            busy_reject,
  output logic            req_done,
  output logic            req_err,
  output logic            rst_cmd_req,
  output logic            rst_dat_req
);
  stage_t state;
  logic   cmd_pend, data_pend, data_done;
  logic   err_hit, cc_now, tc_now, cmd_left, data_left, complete_ok;

  assign busy       = (state != ST_IDLE);
  assign accept     = cmd_wr && (state == ST_IDLE);
  assign issue_fire = (state == ST_WAIT) && gate_ok;
  assign err_hit    = (state == ST_ACTIVE) && |(ev & ERROR_MASK);
  assign cc_now     = cmd_pend && ev[SRC_CC];
  assign tc_now     = data_pend && ev[SRC_TC];
  assign cmd_left   = cmd_pend && !ev[SRC_CC];
  assign data_left  = data_pend && !data_done && !ev[SRC_TC];
  assign complete_ok = (state == ST_ACTIVE) && !err_hit &&
                       (cc_now || tc_now) && !cmd_left && !data_left;
  assign sig_clr    = complete_ok || ((state == ST_RSTD) && rst_dat_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cmd_pend    <= 1'b0;
      data_pend   <= 1'b0;
      data_done   <= 1'b0;
      busy_reject <= 1'b0;
      req_done    <= 1'b0;
      req_err     <= 1'b0;
      rst_cmd_req <= 1'b0;
      rst_dat_req <= 1'b0;
    end else begin
      busy_reject <= cmd_wr && busy;
      req_done    <= 1'b0;
      req_err     <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_wr) state <= ST_WAIT;
        ST_WAIT: if (gate_ok) begin
          state     <= ST_ACTIVE;
          cmd_pend  <= 1'b1;
          data_pend <= need_data;
          data_done <= 1'b0;
        end
        ST_ACTIVE: begin
          if (err_hit) begin
            state       <= ST_RSTC;
            rst_cmd_req <= 1'b1;
          end else if (complete_ok) begin
            state     <= ST_IDLE;
            req_done  <= 1'b1;
            cmd_pend  <= 1'b0;
            data_pend <= 1'b0;
            data_done <= 1'b0;
          end else begin
            if (cc_now) cmd_pend  <= 1'b0;
            if (tc_now) data_done <= 1'b1;
          end
        end
        ST_RSTC: if (rst_cmd_done) begin
          rst_cmd_req <= 1'b0;
          rst_dat_req <= 1'b1;
          state       <= ST_RSTD;
        end
        ST_RSTD: if (rst_dat_done) begin
          rst_dat_req <= 1'b0;
          req_done    <= 1'b1;
          req_err     <= 1'b1;
          state       <= ST_IDLE;
          cmd_pend    <= 1'b0;
          data_pend   <= 1'b0;
          data_done   <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cmd_ctrl.sv
module sdc_cmd_ctrl
  import sdc_pkg::*;
#(
  parameter int ARG_W  = 32,
  parameter int BSZ_W  = 16,
  parameter int BCNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_wr,
  input  logic [5:0]              cmd_idx,
  input  logic [1:0]              cmd_rsp,
  input  logic                    cmd_data,
  input  logic                    cmd_multi,
  input  logic                    cmd_abort,
  input  logic [ARG_W-1:0]        cmd_arg,
  input  logic [BSZ_W-1:0]        blk_size,
  input  logic [BCNT_W-1:0]       blk_cnt,
  input  logic                    cmd_inhibit,
  input  logic                    dat_inhibit,
  input  logic [NSRC-1:0]         ev_in,
  input  logic                    clr_we,
  input  logic [NSRC-1:0]         clr_mask,
  input  logic                    rst_cmd_done,
  input  logic                    rst_dat_done,
  output logic                    issue_valid,
  output logic [11:0]             issue_word,
  output logic [ARG_W-1:0]        issue_arg,
  output logic [BSZ_W+BCNT_W-1:0] issue_attr,
  output logic                    rst_cmd_req,
  output logic                    rst_dat_req,
  output logic [NSRC-1:0]         int_status,
  output logic [NSRC-1:0]         int_sts_en,
  output logic [NSRC-1:0]         int_sig_en,
  output logic                    irq,
  output logic                    busy,
  output logic                    busy_reject,
  output logic                    req_done,
  output logic                    req_err
);
  localparam int ATTR_W = BSZ_W + BCNT_W;

  cmd_word_t         hold_word, built_word;
  logic [ARG_W-1:0]  hold_arg;
  logic [ATTR_W-1:0] hold_attr;
  logic gate_ok, need_data, accept, issue_fire, sig_clr;

  sdc_issue_gate u_gate (
    .wr_idx(cmd_idx), .wr_rsp(cmd_rsp), .wr_data(cmd_data),
    .wr_multi(cmd_multi), .wr_abort(cmd_abort), .held(hold_word),
    .cmd_inh(cmd_inhibit), .dat_inh(dat_inhibit), .built(built_word),
    .gate_ok(gate_ok), .need_data(need_data)
  );

  sdc_stage_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .gate_ok(gate_ok),
    .need_data(need_data), .ev(ev_in), .rst_cmd_done(rst_cmd_done),
    .rst_dat_done(rst_dat_done), .accept(accept), .issue_fire(issue_fire),
    .sig_clr(sig_clr), .busy(busy), .busy_reject(busy_reject),
    .req_done(req_done), .req_err(req_err), .rst_cmd_req(rst_cmd_req),
    .rst_dat_req(rst_dat_req)
  );

  sdc_irq_regs u_irq (
    .clk(clk), .rst(rst), .ev(ev_in), .clr_we(clr_we), .clr_mask(clr_mask),
    .accept(accept), .sig_clr(sig_clr), .sts(int_status),
    .sts_en(int_sts_en), .sig_en(int_sig_en), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word   <= '0;
      hold_arg    <= '0;
      hold_attr   <= '0;
      issue_valid <= 1'b0;
      issue_word  <= '0;
      issue_arg   <= '0;
      issue_attr  <= '0;
    end else begin
      issue_valid <= issue_fire;
      if (accept) begin
        hold_word <= built_word;
        hold_arg  <= cmd_arg;
        hold_attr <= {blk_cnt, blk_size};
      end
      if (issue_fire) begin
        issue_word <= hold_word;
        issue_arg  <= hold_arg;
        issue_attr <= hold_attr;
      end
    end
  end
endmodule

// File: rtl/sdc_cmd_ctrl_chk.sv
module sdc_cmd_ctrl_chk
  import sdc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            cmd_wr,
  input logic            cmd_inhibit,
  input logic            dat_inhibit,
  input logic            issue_valid,
  input logic [11:0]     issue_word,
  input logic            rst_cmd_req,
  input logic            rst_dat_req,
  input logic [NSRC-1:0] int_status,
  input logic [NSRC-1:0] int_sts_en,
  input logic [NSRC-1:0] int_sig_en,
  input logic            irq,
  input logic            busy,
  input logic            busy_reject,
  input logic            req_done
);
  AST_CMD_GATE: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> $past(!cmd_inhibit)); // R1
  AST_DAT_GATE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_word[7:6] == 2'd3 && !issue_word[10]) |-> $past(!dat_inhibit)); // R2
  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (issue_word[11] == (issue_word[8] && issue_word[9]))); // R3
  AST_STS_GATED: assert property (@(posedge clk) disable iff (rst)
    (int_status & ~$past(int_status) & ~$past(int_sts_en)) == '0); // R5
  AST_RST_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rst_cmd_req && rst_dat_req)); // R9
  AST_RST_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_dat_req) |-> $past(rst_cmd_req)); // R9
  AST_DONE_SIG_OFF: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (int_sig_en == '0)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !irq); // R10
  AST_REJECT_SRC: assert property (@(posedge clk) disable iff (rst)
    busy_reject |-> $past(cmd_wr && busy)); // R11
endmodule

bind sdc_cmd_ctrl sdc_cmd_ctrl_chk u_chk (.*);

// File: tb/sdc_cmd_ctrl_tb.sv
module sdc_cmd_ctrl_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_wr = 0, cmd_data = 0, cmd_multi = 0, cmd_abort = 0;
  logic [5:0] cmd_idx = 0;
  logic [1:0] cmd_rsp = 0;
  logic [31:0] cmd_arg = 0;
  logic [15:0] blk_size = 0, blk_cnt = 0;
  logic cmd_inhibit = 0, dat_inhibit = 0, clr_we = 0;
  logic [15:0] ev_in = 0, clr_mask = 0;
  logic rst_cmd_done = 0, rst_dat_done = 0;
  logic issue_valid, rst_cmd_req, rst_dat_req, irq, busy, busy_reject, req_done, req_err;
  logic [11:0] issue_word;
  logic [31:0] issue_arg, issue_attr;
  logic [15:0] int_status, int_sts_en, int_sig_en;

  int checks = 0, errors = 0, issue_cnt = 0, done_cnt = 0;
  logic [75:0] q_issue[$];
  logic q_err[$];
  string q_tag[$];

  always #10 clk = ~clk;

  sdc_cmd_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [5:0] idx, input logic [1:0] rsp, input logic dp,
                        input logic mb, input logic ab, input logic [31:0] arg,
                        input logic [15:0] bs, input logic [15:0] bc);
    @(negedge clk);
    cmd_wr = 1; cmd_idx = idx; cmd_rsp = rsp; cmd_data = dp; cmd_multi = mb;
    cmd_abort = ab; cmd_arg = arg; blk_size = bs; blk_cnt = bc;
    q_issue.push_back({dp && mb, ab, mb, dp, rsp, idx, arg, bc, bs});
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic pulse(input logic [15:0] bits);
    @(negedge clk); ev_in = bits;
    @(negedge clk); ev_in = '0;
  endtask

  task automatic expect_done(input logic e, input string tag);
    q_err.push_back(e); q_tag.push_back(tag);
  endtask

  // Monitor: compares launches and retirements against the scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && issue_valid) begin
      issue_cnt++;
      if (q_issue.size() == 0) chk("R1 unexpected issue", 1, 0);
      else begin
        logic [75:0] e;
        e = q_issue.pop_front();
        chk("R3 issue_word", {20'd0, issue_word}, {20'd0, e[75:64]});
        chk("R4 issue_arg", issue_arg, e[63:32]);
        chk("R4 issue_attr", issue_attr, e[31:0]);
      end
    end
    if (!rst && req_done) begin
      done_cnt++;
      if (q_err.size() == 0) chk("R7 unexpected done", 1, 0);
      else begin
        logic ee;
        string tg;
        ee = q_err.pop_front(); tg = q_tag.pop_front();
        chk({tg, " req_err"}, {31'd0, req_err}, {31'd0, ee});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ic;
    cyc(3); rst = 0; cyc(1);
    chk("R10 reset busy", {31'd0, busy}, 0);
    chk("R10 reset irq", {31'd0, irq}, 0);
    chk("R10 reset sig_en", {16'd0, int_sig_en}, 0);
    chk("R5 reset status", {16'd0, int_status}, 0);
    // R5: events with status-enable zero leave status clear
    pulse(16'h0023);
    chk("R5 gated event", {16'd0, int_status}, 0);

    // R8 plain 48-bit command, no data
    do_cmd(6'd17, 2'd2, 0, 0, 0, 32'hDEAD_0001, 16'd512, 16'd3);
    chk("R6 masks loaded", {int_sts_en, int_sig_en}, 32'hFFFF_FFFF);
    cyc(2);
    chk("R1 issued", issue_cnt, 1);
    pulse(16'h0020);
    chk("R5 block gap set", {16'd0, int_status}, 32'h0020);
    chk("R10 irq active", {31'd0, irq}, 1);
    // R11 reject while busy
    @(negedge clk); cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    chk("R11 busy_reject", {31'd0, busy_reject}, 1);
    cyc(2);
    chk("R11 no extra issue", issue_cnt, 1);
    expect_done(0, "R8");
    pulse(16'h0001);
    chk("R8 retired", {31'd0, busy}, 0);
    chk("R10 sig_en cleared", {16'd0, int_sig_en}, 0);
    chk("R10 irq idle", {31'd0, irq}, 0);
    chk("R5 status kept", {16'd0, int_status}, 32'h0021);
    @(negedge clk); clr_we = 1; clr_mask = 16'h0020;
    @(negedge clk); clr_we = 0;
    chk("R5 w1c", {16'd0, int_status}, 32'h0001);
    // R5 set wins over clear
    @(negedge clk); clr_we = 1; clr_mask = 16'h0004; ev_in = 16'h0004;
    @(negedge clk); clr_we = 0; ev_in = 0;
    chk("R5 set wins", {16'd0, int_status}, 32'h0005);

    // R1 command inhibit holds launch; R6 pending status cleared
    cmd_inhibit = 1;
    do_cmd(6'd8, 2'd1, 0, 0, 0, 32'h0000_01AA, 16'd0, 16'd0);
    chk("R6 status cleared", {16'd0, int_status}, 0);
    cyc(5);
    chk("R1 held", issue_cnt, 1);
    cmd_inhibit = 0; cyc(2);
    chk("R1 released", issue_cnt, 2);
    expect_done(0, "R8");
    pulse(16'h0001);

    // R2 busy response waits for data inhibit; R7 TC before CC
    dat_inhibit = 1;
    do_cmd(6'd7, 2'd3, 0, 0, 0, 32'h0001_0000, 16'd0, 16'd0);
    cyc(4);
    chk("R2 busy held", issue_cnt, 2);
    dat_inhibit = 0; cyc(2);
    chk("R2 busy released", issue_cnt, 3);
    pulse(16'h0002);
    chk("R7 waits for CC", {31'd0, busy}, 1);
    expect_done(0, "R7");
    pulse(16'h0001);
    chk("R7 tc-cc retired", {31'd0, busy}, 0);

    // R2 abort bypasses data inhibit; R7 CC before TC
    dat_inhibit = 1;
    do_cmd(6'd12, 2'd3, 0, 0, 1, 32'h0, 16'd0, 16'd0);
    cyc(2);
    chk("R2 abort issues", issue_cnt, 4);
    pulse(16'h0001);
    chk("R7 waits for TC", {31'd0, busy}, 1);
    expect_done(0, "R7");
    pulse(16'h0002);
    chk("R7 cc-tc retired", {31'd0, busy}, 0);
    dat_inhibit = 0;

    // R3/R4 multi-block read gets auto-stop, single-block does not
    do_cmd(6'd18, 2'd2, 1, 1, 0, 32'h0000_4000, 16'd512, 16'd9);
    cyc(2);
    expect_done(0, "R3");
    pulse(16'h0003);
    do_cmd(6'd17, 2'd2, 1, 0, 0, 32'h0000_8000, 16'd64, 16'd1);
    cyc(2);

    // R9 error recovery on the active data request
    expect_done(1, "R9");
    pulse(16'h0800);
    chk("R9 cmd reset req", {30'd0, rst_cmd_req, rst_dat_req}, 32'h2);
    cyc(3);
    chk("R9 cmd reset held", {30'd0, rst_cmd_req, rst_dat_req}, 32'h2);
    @(negedge clk); rst_cmd_done = 1;
    @(negedge clk); rst_cmd_done = 0;
    chk("R9 dat reset req", {30'd0, rst_cmd_req, rst_dat_req}, 32'h1);
    chk("R9 still busy", {31'd0, busy}, 1);
    @(negedge clk); rst_dat_done = 1;
    @(negedge clk); rst_dat_done = 0;
    chk("R9 resets dropped", {30'd0, rst_cmd_req, rst_dat_req}, 0);
    chk("R9 retired", {31'd0, busy}, 0);
    chk("R10 irq after error", {31'd0, irq}, 0);
    cyc(2);

    ic = q_issue.size() + q_err.size();
    chk("R7 scoreboard drained", ic, 0);
    chk("R7 done count", done_cnt, 6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule